// File: doc/BRIEF.md
# Load-Use Bubble Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It compares the destination register of a load that is now in the execute stage with the two source fields of the instruction being decoded. A load's data only exists once the memory stage has finished, so forwarding cannot serve a consumer that directly follows the load. In that case the block holds the program counter and the fetch/decode register for one cycle and sends a bubble into the decode/execute register. The bubble is formed by clearing every execute, memory and writeback control bit. After that single cycle the loaded value can be forwarded from the memory/writeback register, so one bubble is enough.

The decode unit's control word passes through the block. On a bubble cycle the whole word is cleared, which gives the no-op. On every other cycle it passes unchanged. A guard register keeps a stall from being repeated on the next cycle. The fetch and decode stages hold while the load moves ahead, and the consumer that follows it is delayed along with it, so its forwarding paths still line up.

Top module: `lu_stall_ctrl`

## Requirements
- R1: After reset, with no load in execute, pc_we and ifid_we are 1, ctl_zero is 0 and ctl_out equals ctl_in.
- R2: When ex_mem_rd is 1 and ex_rt is non-zero and equal to id_rs, the block stalls in the same cycle.
- R3: When ex_mem_rd is 1 and ex_rt is non-zero and equal to id_rt, the block stalls in the same cycle.
- R4: A load whose destination is register 0 never causes a stall, even when the source fields are 0.
- R5: When ex_mem_rd is 0, no register match causes a stall.
- R6: On a stall cycle pc_we and ifid_we are both 0 and ctl_zero is 1. On every other cycle the enables are 1 and ctl_zero is 0.
- R7: On a stall cycle all nine bits of ctl_out are 0. The bit layout is [8] ALU source, [7:6] ALU op, [5] destination select, [4] memory read, [3] memory write, [2] PC source, [1] register write, [0] memory-to-register.
- R8: On a cycle without a stall, ctl_out equals ctl_in bit for bit.
- R9: A stall lasts exactly one cycle. In the cycle after a stall no stall occurs, even if the hazard inputs stay unchanged. A hazard that follows a cycle without a stall stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the one-cycle guard |
| ex_mem_rd | input | 1 | Memory-read flag held in the decode/execute register |
| ex_rt | input | REG_AW | Load destination held in the decode/execute register |
| id_rs | input | REG_AW | First source field of the instruction in decode |
| id_rt | input | REG_AW | Second source field of the instruction in decode |
| ctl_in | input | 9 | Control word from the decoder |
| ctl_out | output | 9 | Control word sent to the decode/execute register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctl_zero | output | 1 | High on a bubble cycle |

## Verification
Directed cases separate a match on the first source field from a match on the second, and check each against a load to register 0 and against a matching non-load, so that a comparator wired to the wrong field or missing the zero test shows up. Holding the hazard inputs across two cycles tells a one-shot stall apart from a repeating one. A later hazard then shows that the guard releases. A long random run over a four-register space mixes loads and non-loads with frequent matches. A behavioural model compares every output on every cycle, including pass-through control words with assorted bit patterns.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int ALUOP_W = 2;
  localparam int CTL_W   = 7 + ALUOP_W;
  localparam int B_MEM2REG = 0;
  localparam int B_REGWR   = 1;
  localparam int B_PCSRC   = 2;
  localparam int B_MEMWR   = 3;
  localparam int B_MEMRD   = 4;
  localparam int B_DSTSEL  = 5;
  localparam int B_ALUOP   = 6;
  localparam int B_ALUSRC  = 6 + ALUOP_W;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int REG_AW = 5
) (
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  output logic              hit_rs,
  output logic              hit_rt,
  output logic              hit
);
  function automatic logic dep(input logic rd, input logic [REG_AW-1:0] dst,
                               input logic [REG_AW-1:0] src);
    return rd && (dst != '0) && (dst == src);
  endfunction

  always_comb begin
    hit_rs = dep(ex_mem_rd, ex_rt, id_rs);
    hit_rt = dep(ex_mem_rd, ex_rt, id_rt);
    hit    = hit_rs | hit_rt;
  end
endmodule

// File: rtl/lu_ctl_gate.sv
module lu_ctl_gate #(
  parameter int W = 9
) (
  input  logic         zero,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = d[i] & ~zero;
  end
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [CTL_W-1:0]  ctl_in,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              ctl_zero
);
  logic hit_rs, hit_rt, hazard_hit;
  logic guard_q;
  logic stall;

  lu_hazard_detect #(.REG_AW(REG_AW)) u_det (
    .ex_mem_rd (ex_mem_rd),
    .ex_rt     (ex_rt),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .hit_rs    (hit_rs),
    .hit_rt    (hit_rt),
    .hit       (hazard_hit)
  );

  if (ONE_SHOT) begin : g_guard
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) guard_q <= 1'b0;
      else        guard_q <= stall;
    end
  end else begin : g_noguard
    assign guard_q = 1'b0;
  end

  assign stall    = hazard_hit & ~guard_q;
  assign pc_we    = ~stall;
  assign ifid_we  = ~stall;
  assign ctl_zero = stall;

  lu_ctl_gate #(.W(CTL_W)) u_gate (
    .zero (stall),
    .d    (ctl_in),
    .q    (ctl_out)
  );
endmodule

// File: rtl/lu_stall_ctrl_chk.sv
module lu_stall_ctrl_chk
  import lu_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter bit ONE_SHOT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ex_mem_rd,
  input logic [REG_AW-1:0] ex_rt,
  input logic [REG_AW-1:0] id_rs,
  input logic [REG_AW-1:0] id_rt,
  input logic [CTL_W-1:0]  ctl_in,
  input logic [CTL_W-1:0]  ctl_out,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              ctl_zero,
  input logic              guard_q
);
  AST_STALL_ON_RS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_rt != '0 && ex_rt == id_rs && !guard_q) |-> ctl_zero); // R2
  AST_STALL_ON_RT: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_rt != '0 && ex_rt == id_rt && !guard_q) |-> ctl_zero); // R3
  AST_REG_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == '0) |-> !ctl_zero); // R4
  AST_NO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> !ctl_zero); // R5
  AST_FREEZE_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |-> (!pc_we && !ifid_we)); // R6
  AST_RUN_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_zero |-> (pc_we && ifid_we)); // R6
  AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |-> (ctl_out == '0)); // R7
  AST_CTL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_zero |-> (ctl_out == ctl_in)); // R8
  if (ONE_SHOT) begin : g_one
    AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_zero |=> !ctl_zero); // R9
  end
endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(.REG_AW(REG_AW), .ONE_SHOT(ONE_SHOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_mem_rd(ex_mem_rd), .ex_rt(ex_rt),
  .id_rs(id_rs), .id_rt(id_rt), .ctl_in(ctl_in), .ctl_out(ctl_out),
  .pc_we(pc_we), .ifid_we(ifid_we), .ctl_zero(ctl_zero), .guard_q(guard_q)
);

// File: tb/lu_stall_ctrl_bench.sv
module lu_stall_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ex_mem_rd = 1'b0;
  logic [AW-1:0] ex_rt = '0, id_rs = '0, id_rt = '0;
  logic [8:0]    ctl_in = '0;
  logic [8:0]    ctl_out;
  logic          pc_we, ifid_we, ctl_zero;

  int n_chk = 0;
  int n_fail = 0;
  int last_stall = 0;

  always #(CLK_P/2) clk = ~clk;

  lu_stall_ctrl #(.REG_AW(AW)) u_lu_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .ex_mem_rd(ex_mem_rd), .ex_rt(ex_rt),
    .id_rs(id_rs), .id_rt(id_rt), .ctl_in(ctl_in), .ctl_out(ctl_out),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_zero(ctl_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: stall when a load targets a non-zero register named by either
  // source field, unless the previous cycle already stalled.
  task automatic step(input logic mr, input int dst, input int s1, input int s2,
                      input int ctl, input string req);
    int exp_stall;
    int exp_ctl;
    @(negedge clk);
    ex_mem_rd = mr; ex_rt = AW'(dst); id_rs = AW'(s1); id_rt = AW'(s2);
    ctl_in = 9'(ctl);
    #1;
    exp_stall = 0;
    if (mr && dst != 0 && last_stall == 0)
      if (dst == s1 || dst == s2) exp_stall = 1;
    exp_ctl = exp_stall ? 0 : (ctl & 9'h1FF);
    check({req, " stall"}, int'(ctl_zero), exp_stall);
    check("R6 pc_we", int'(pc_we), 1 - exp_stall);
    check("R6 ifid_we", int'(ifid_we), 1 - exp_stall);
    check(exp_stall ? "R7 ctl_out" : "R8 ctl_out", int'(ctl_out), exp_ctl);
    @(posedge clk);
    last_stall = exp_stall;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    ctl_in = 9'h1A5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc_we", int'(pc_we), 1);
    check("R1 ifid_we", int'(ifid_we), 1);
    check("R1 ctl_zero", int'(ctl_zero), 0);
    check("R1 ctl_out", int'(ctl_out), 'h1A5);
    rst_n = 1'b1;
    @(posedge clk);

    step(1'b0, 4, 4, 6, 'h1A5, "R1");
    step(1'b1, 5, 5, 2, 'h1FF, "R2");
    step(1'b1, 5, 5, 2, 'h0C3, "R9");   // held inputs: no second bubble
    step(1'b0, 0, 1, 1, 'h155, "R8");
    step(1'b1, 7, 3, 7, 'h0AA, "R3");
    step(1'b0, 7, 7, 7, 'h133, "R5");
    step(1'b1, 0, 0, 0, 'h1FF, "R4");
    step(1'b1, 9, 9, 9, 'h17E, "R9");   // guard released
    step(1'b1, 9, 1, 2, 'h011, "R8");

    for (int i = 0; i < 600; i++) begin
      step(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 511), "R2 R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule